// File: doc/BRIEF.md
# Trigger-Configurable Interrupt Controller

This block gathers 64 synchronous interrupt sources, organised as two banks of 32, and turns them into one interrupt line per bank. Each source has its own two-bit trigger field. The field selects one of four detection modes: level active-high, level active-low, rising edge or falling edge. Level sources report their current (possibly inverted) input with no memory. Edge sources set a sticky latch when the selected transition occurs.

Software uses a plain 32-bit register port with an address, a write strobe, write data and combinational read data. For each bank it can program the trigger fields, hold or release per-source clear bits, set mask bits and read the raw detected condition. An edge latch is cleared by writing its clear bit to 1 and then back to 0. The same pulse, issued after a trigger change, discards any event left over from the previous mode. Each bank's output is a registered OR of its detected sources that are not masked.

Top module: `trig_irq_ctrl`

## Requirements
- R1: Bank b occupies byte addresses b*0x20 to b*0x20+0x1F. Source index equals b*32 plus the bit number, and the registers of one bank never affect the other bank.
- R2: Trigger fields are 2 bits wide with 16 per word. For source bit s of a bank, the field is in the word at bank offset 0x04+4*(s/16), bits [2*(s%16)+1 : 2*(s%16)]. Code 0 selects level active-high, 1 selects level active-low, 2 selects rising edge and 3 selects falling edge.
- R3: For a level source, its status bit (bank offset 0x1C) equals the current input, inverted for active-low, with no latching.
- R4: For an edge source, its status bit becomes 1 on the clock edge where the input differs from its value one cycle earlier in the selected direction. The bit then stays 1 until cleared, and the opposite transition never sets it.
- R5: While a source's clear bit (bank offset 0x10) is 1, its edge latch is held at 0 and edges are discarded. Releasing the clear bit does not recover an edge that occurred while the bit was held.
- R6: A latch set under an edge mode survives a change of trigger field. A set-then-release pulse of the clear bit then removes it.
- R7: A mask bit (bank offset 0x14) of 1 keeps that source off the bank output but leaves its status bit unchanged.
- R8: Each irq_out bit is the OR of status AND NOT mask over its bank, registered once. It reflects the register state one clock edge later.
- R9: After reset all trigger fields read 0, all mask bits read 1, all clear bits read 0, all edge latches are 0 and irq_out is 0.
- R10: Reads from unmapped addresses return 0. Writes to the status register or to unmapped addresses change nothing.
- R11: Trigger, clear and mask registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 64 | Interrupt sources, synchronous to clk |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address (combinational) |
| irq_out | output | 2 | Per-bank interrupt line |

## Verification
The assertions assume that src_in, addr, wr_en and wdata are free of unknowns and change only between clock edges, so that each edge sees one settled value. They also assume that level sources cannot set an edge latch, and they tie the clear and mask registers to the latch and output behaviour one cycle later. The stimulus drives every input just after a rising edge and samples at the falling edge. It issues one register write per cycle and holds each source level for at least one full clock before reversing it, so that every transition is seen exactly once.

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl #(
  parameter int NBANK = 2,
  parameter int NSRC  = 32,
  parameter int AW    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*NSRC-1:0]   src_in,
  input  logic [AW-1:0]           addr,
  input  logic                    wr_en,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic [NBANK-1:0]        irq_out
);
  localparam int TOT  = NBANK * NSRC;
  localparam int PERW = 16;
  localparam int NTW  = NSRC / PERW;
  localparam logic [4:0] OFF_TYPE = 5'h04;
  localparam logic [4:0] OFF_CLR  = 5'h10;
  localparam logic [4:0] OFF_MASK = 5'h14;
  localparam logic [4:0] OFF_STAT = 5'h1C;

  logic [2*TOT-1:0] typ_q;
  logic [TOT-1:0]   clr_q, mask_q, prev_q, edge_q, hit, status;
  logic [NBANK-1:0] irq_q;
  logic [AW-6:0]    bsel;
  logic [4:0]       off;

  assign bsel    = addr[AW-1:5];
  assign off     = addr[4:0];
  assign irq_out = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      typ_q  <= '0;
      clr_q  <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bsel == (AW-5)'(b)) begin
          for (int w = 0; w < NTW; w++)
            if (off == OFF_TYPE + 5'(4*w))
              typ_q[2*(b*NSRC + w*PERW) +: 32] <= wdata;
          if (off == OFF_CLR)  clr_q[b*NSRC +: NSRC]  <= wdata[NSRC-1:0];
          if (off == OFF_MASK) mask_q[b*NSRC +: NSRC] <= wdata[NSRC-1:0];
        end
      end
    end
  end

  for (genvar i = 0; i < TOT; i++) begin : g_src
    assign hit[i] = typ_q[2*i+1] &
                    (typ_q[2*i] ? (prev_q[i] & ~src_in[i]) : (~prev_q[i] & src_in[i]));
    assign status[i] = typ_q[2*i+1] ? edge_q[i] : (src_in[i] ^ typ_q[2*i]);

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!typ_q[2*i+1] && !edge_q[i]) |=> !edge_q[i]) else $error("level source latched"); // R3
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
      irq_q  <= '0;
    end else begin
      prev_q <= src_in;
      edge_q <= (edge_q | hit) & ~clr_q;
      for (int b = 0; b < NBANK; b++)
        irq_q[b] <= |(status[b*NSRC +: NSRC] & ~mask_q[b*NSRC +: NSRC]);
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bsel == (AW-5)'(b)) begin
        for (int w = 0; w < NTW; w++)
          if (off == OFF_TYPE + 5'(4*w))
            rdata = typ_q[2*(b*NSRC + w*PERW) +: 32];
        if (off == OFF_CLR)  rdata[NSRC-1:0] = clr_q[b*NSRC +: NSRC];
        if (off == OFF_MASK) rdata[NSRC-1:0] = mask_q[b*NSRC +: NSRC];
        if (off == OFF_STAT) rdata[NSRC-1:0] = status[b*NSRC +: NSRC];
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q[b*NSRC +: NSRC]) |=> !irq_out[b]) else $error("masked bank raised irq"); // R7
  end

  AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q != '0) |=> ((edge_q & $past(clr_q)) == '0)) else $error("latch set under clear"); // R5

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_q & ~clr_q) != '0) |=> ((($past(edge_q) & ~$past(clr_q)) & ~edge_q) == '0))
    else $error("edge latch dropped"); // R4
endmodule

// File: tb/tb_trig_irq_ctrl.sv
module tb_trig_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src_in = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq_out;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] msk;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  trig_irq_ctrl dut (.clk, .rst_n, .src_in, .addr, .wr_en, .wdata, .rdata, .irq_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = q.pop_front();
        got = it.is_irq ? {30'b0, irq_out} : rdata;
        checks++;
        if ((got & it.msk) !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h (mask %h)", it.req, got & it.msk, it.exp, it.msk);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1; step(); wr_en = 0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] m, input logic [31:0] e, input string r);
    addr = a; q.push_back('{0, m, e, r}); step();
  endtask

  task automatic exp_irq(input logic [1:0] e, input string r);
    q.push_back('{1, 32'h3, {30'b0, e}, r}); step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    exp_rd(8'h14, '1, 32'hFFFF_FFFF, "R9 mask0 reset");
    exp_rd(8'h34, '1, 32'hFFFF_FFFF, "R9 mask1 reset");
    exp_rd(8'h04, '1, 32'h0, "R9 type reset");
    exp_rd(8'h10, '1, 32'h0, "R9 clear reset");
    exp_rd(8'h1C, '1, 32'h0, "R9 status reset");
    exp_irq(2'b00, "R9 irq reset");
    exp_rd(8'h00, '1, 32'h0, "R10 unmapped 0x00");
    exp_rd(8'h18, '1, 32'h0, "R10 unmapped 0x18");
    exp_rd(8'h60, '1, 32'h0, "R10 unmapped bank3");

    src_in[3] = 1;
    exp_rd(8'h1C, 32'h8, 32'h8, "R3 level high");
    exp_irq(2'b00, "R7 masked source quiet");
    wr(8'h14, ~32'h8);
    exp_irq(2'b00, "R8 one-cycle latency");
    exp_irq(2'b01, "R8 bank0 irq");
    exp_rd(8'h14, '1, 32'hFFFF_FFF7, "R11 mask readback");

    wr(8'h04, 32'h400);
    exp_rd(8'h04, '1, 32'h400, "R11 type readback");
    exp_rd(8'h1C, 32'h20, 32'h20, "R2 R3 active-low with input 0");
    src_in[5] = 1;
    exp_rd(8'h1C, 32'h20, 32'h0, "R3 active-low with input 1");

    wr(8'h08, 32'h200);
    wr(8'h10, 32'h10_0000); wr(8'h10, 32'h0);
    exp_rd(8'h1C, 32'h10_0000, 32'h0, "R4 rising idle");
    src_in[20] = 1; step();
    src_in[20] = 0;
    exp_rd(8'h1C, 32'h10_0000, 32'h10_0000, "R4 rising sticky");
    step();
    exp_rd(8'h1C, 32'h10_0000, 32'h10_0000, "R4 falling ignored on rising");

    wr(8'h10, 32'h10_0000);
    exp_rd(8'h10, '1, 32'h10_0000, "R11 clear readback");
    src_in[20] = 1; step();
    exp_rd(8'h1C, 32'h10_0000, 32'h0, "R5 clear held");
    wr(8'h10, 32'h0);
    exp_rd(8'h1C, 32'h10_0000, 32'h0, "R5 no late event");
    src_in[20] = 0; step();
    src_in[20] = 1; step();
    exp_rd(8'h1C, 32'h10_0000, 32'h10_0000, "R4 re-armed rise");

    src_in[20] = 0;
    wr(8'h08, 32'h0);
    exp_rd(8'h1C, 32'h10_0000, 32'h0, "R6 level view");
    wr(8'h08, 32'h200);
    exp_rd(8'h1C, 32'h10_0000, 32'h10_0000, "R6 stale latch kept");
    wr(8'h10, 32'h10_0000); wr(8'h10, 32'h0);
    exp_rd(8'h1C, 32'h10_0000, 32'h0, "R6 pulse removes stale");

    src_in[40] = 1; step();
    wr(8'h24, 32'h3_0000);
    wr(8'h30, 32'h100); wr(8'h30, 32'h0);
    exp_rd(8'h3C, 32'h100, 32'h0, "R4 falling idle");
    exp_rd(8'h1C, 32'h10_0000, 32'h0, "R1 bank0 untouched");
    src_in[40] = 0; step();
    exp_rd(8'h3C, 32'h100, 32'h100, "R4 falling latched bank1");
    wr(8'h34, ~32'h100); step();
    exp_irq(2'b11, "R8 both banks");

    wr(8'h14, 32'hFFFF_FFFF); step();
    exp_irq(2'b10, "R7 bank0 masked");
    exp_rd(8'h1C, 32'h8, 32'h8, "R7 status unmasked view");

    wr(8'h3C, 32'h0);
    exp_rd(8'h3C, 32'h100, 32'h100, "R10 status write ignored");
    wr(8'h18, 32'hFFFF);
    exp_rd(8'h18, '1, 32'h0, "R10 unmapped write ignored");
    exp_rd(8'h30, '1, 32'h0, "R1 bank1 clear");
    exp_rd(8'h24, '1, 32'h3_0000, "R1 R11 bank1 type readback");
    exp_rd(8'h28, '1, 32'h0, "R1 bank1 upper type word");

    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule